// File: doc/BRIEF.md
# Single-Cycle RISC-V Integer Subset Core

This block is a processor core that runs a narrow slice of the 64-bit RISC-V integer instruction set. It handles four kinds of instruction: register-to-register arithmetic and logic (add, sub, and, or), doubleword load, doubleword store, and branch-if-equal. Each instruction is fetched, decoded, executed and retired within a single clock cycle. There is no pipelining, no hazard handling and no exception path.

The core holds the program counter and a 32-entry register file. Control is split across two decoders. The main decoder looks only at the 7-bit opcode and produces the operand-select, write-back-select, write-enable, memory-strobe and branch controls, along with a 2-bit ALU class. A second decoder turns that class, together with funct3 and bit 5 of funct7, into one ALU function.

The instruction memory and the data memory sit outside the core. Both are read combinationally from the address the core drives, and the data memory is written on the rising clock edge while the store strobe is high.

The asynchronous active-low reset is released through a two-stage synchroniser inside the core.

Top module: `sc_rv_core`

## Requirements
- R1: While rst_n is low, and for the first two rising edges after it rises, imem_addr is 0 and both dmem_wen and dmem_ren are low. The instruction at address 0 retires on the third rising edge, reading every register as zero.
- R2: Opcode 0110011 (instr[6:0]) writes the ALU result of rs1 (instr[19:15]) and rs2 (instr[24:20]) into rd (instr[11:7]). It raises no memory strobe.
- R3: For opcode 0110011 the operation is chosen by funct3 (instr[14:12]) and funct7 bit 5 (instr[30]). The codes are: 000 with bit 5 clear is add, 000 with bit 5 set is subtract, 111 is and, and 110 is or. All arithmetic is 64-bit and wraps.
- R4: Opcode 0000011 raises dmem_ren and drives dmem_addr = x[rs1] + sign-extended instr[31:20]. It writes dmem_rdata into rd.
- R5: Opcode 0100011 raises dmem_wen and drives dmem_addr = x[rs1] + sign-extended {instr[31:25], instr[11:7]}, with dmem_wdata = x[rs2]. It leaves every register unchanged.
- R6: Opcode 1100011 compares x[rs1] and x[rs2]. When they are equal, the next PC is PC + 2 × sign-extended {instr[31], instr[7], instr[30:25], instr[11:8]}. Otherwise the next PC is PC + 4. This holds for both forward and backward offsets.
- R7: Every instruction other than a taken branch advances the PC by 4. imem_addr is always a multiple of 4.
- R8: Register x0 reads as zero. A write aimed at x0 is discarded.
- R9: Any other opcode changes no register and no memory location, raises no strobe, and advances the PC by 4.
- R10: dmem_wen and dmem_ren are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_addr | output | 64 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, combinational |
| dmem_addr | output | 64 | Byte address for a load or store |
| dmem_wdata | output | 64 | Store data |
| dmem_wen | output | 1 | Store strobe; memory writes on the rising edge |
| dmem_ren | output | 1 | Load strobe |
| dmem_rdata | input | 64 | Load data at dmem_addr, combinational |

## Verification
Several properties are checked on every cycle by assertions:
- the PC steps by 4 or jumps to the branch target after each retirement;
- the PC stays word aligned;
- the two memory strobes are exclusive;
- the strobes stay low during reset;
- x0 reads as zero on both ports;
- stores and unrecognised opcodes never enable a register write.

Other behaviour is visible only through the bench's scenarios, because the register file has no port:
- the values that arithmetic, logic and loads leave in registers;
- the discarded write to x0;
- the negative load and store offsets;
- the skipped stores behind a taken branch;
- the unrecognised word that would write x1 on a complete core.

These show up in later stores and in the final memory image, which a behavioural reference model predicts cycle by cycle.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam int ILEN = 32;

  localparam logic [6:0] OPC_ALU_RR = 7'b0110011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;

  typedef enum logic [1:0] {
    ACLS_MEM   = 2'b00,
    ACLS_CMP   = 2'b01,
    ACLS_RTYPE = 2'b10
  } alu_class_e;

  typedef enum logic [1:0] {
    FN_ADD,
    FN_SUB,
    FN_AND,
    FN_OR
  } alu_fn_e;

  typedef enum logic [1:0] {
    IMMK_I,
    IMMK_S,
    IMMK_B
  } imm_kind_e;

  typedef struct packed {
    logic       opb_imm;
    logic       wb_from_mem;
    logic       reg_we;
    logic       mem_re;
    logic       mem_we;
    logic       is_branch;
    alu_class_e alu_class;
  } ctrl_t;

endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  opcode,
  input  logic [2:0]  funct3,
  input  logic        funct7_b5,
  output ctrl_t       ctrl,
  output alu_fn_e     alu_fn,
  output imm_kind_e   imm_kind
);

  // Main decoder: opcode only
  always_comb begin
    ctrl     = '{opb_imm: 1'b0, wb_from_mem: 1'b0, reg_we: 1'b0, mem_re: 1'b0,
                 mem_we: 1'b0, is_branch: 1'b0, alu_class: ACLS_MEM};
    imm_kind = IMMK_I;
    case (opcode)
      OPC_ALU_RR: begin
        ctrl.reg_we    = 1'b1;
        ctrl.alu_class = ACLS_RTYPE;
      end
      OPC_LOAD: begin
        ctrl.opb_imm     = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_we      = 1'b1;
        ctrl.mem_re      = 1'b1;
        ctrl.alu_class   = ACLS_MEM;
        imm_kind         = IMMK_I;
      end
      OPC_STORE: begin
        ctrl.opb_imm   = 1'b1;
        ctrl.mem_we    = 1'b1;
        ctrl.alu_class = ACLS_MEM;
        imm_kind       = IMMK_S;
      end
      OPC_BRANCH: begin
        ctrl.is_branch = 1'b1;
        ctrl.alu_class = ACLS_CMP;
        imm_kind       = IMMK_B;
      end
      default: begin
        ctrl.reg_we = 1'b0;
      end
    endcase
  end

  // Second-level ALU control
  always_comb begin
    alu_fn = FN_ADD;
    case (ctrl.alu_class)
      ACLS_MEM: alu_fn = FN_ADD;
      ACLS_CMP: alu_fn = FN_SUB;
      ACLS_RTYPE: begin
        case (funct3)
          3'b000:  alu_fn = funct7_b5 ? FN_SUB : FN_ADD;
          3'b111:  alu_fn = FN_AND;
          3'b110:  alu_fn = FN_OR;
          default: alu_fn = FN_ADD;
        endcase
      end
      default: alu_fn = FN_ADD;
    endcase
  end

  logic opc_known;
  assign opc_known = (opcode == OPC_ALU_RR) || (opcode == OPC_LOAD) ||
                     (opcode == OPC_STORE)  || (opcode == OPC_BRANCH);

  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !opc_known |-> !(ctrl.reg_we || ctrl.mem_re || ctrl.mem_we || ctrl.is_branch)); // R9
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OPC_STORE) |-> !ctrl.reg_we); // R5

endmodule

// File: rtl/core_immgen.sv
module core_immgen
  import core_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [ILEN-1:7] instr_hi,
  input  imm_kind_e       kind,
  output logic [XLEN-1:0] imm
);

  localparam int EXT_W = XLEN - 12;

  logic sign_bit;
  assign sign_bit = instr_hi[31];

  always_comb begin
    case (kind)
      IMMK_S:  imm = {{EXT_W{sign_bit}}, instr_hi[31:25], instr_hi[11:7]};
      // Branch offset in halfword units; the caller shifts it left by one
      IMMK_B:  imm = {{EXT_W{sign_bit}}, instr_hi[31], instr_hi[7],
                      instr_hi[30:25], instr_hi[11:8]};
      default: imm = {{EXT_W{sign_bit}}, instr_hi[31:20]};
    endcase
  end

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int XLEN = 64,
  parameter int NREG = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [XLEN-1:0]       wr_data,
  input  logic [$clog2(NREG)-1:0] rd_idx_a,
  input  logic [$clog2(NREG)-1:0] rd_idx_b,
  output logic [XLEN-1:0]       rd_data_a,
  output logic [XLEN-1:0]       rd_data_b
);

  localparam int IDX_W = $clog2(NREG);

  logic [XLEN-1:0] row_q [NREG];

  assign row_q[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_row
    logic            hit;
    logic [XLEN-1:0] q;
    logic [XLEN-1:0] d;

    always_comb begin
      hit = wr_en && (wr_idx == IDX_W'(g));
      d   = hit ? wr_data : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign row_q[g] = q;
  end

  assign rd_data_a = row_q[rd_idx_a];
  assign rd_data_b = row_q[rd_idx_b];

  AST_X0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_idx_a == '0) |-> (rd_data_a == '0)) and ((rd_idx_b == '0) |-> (rd_data_b == '0))); // R8

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  alu_fn_e         fn,
  output logic [XLEN-1:0] res,
  output logic            zero
);

  always_comb begin
    case (fn)
      FN_SUB:  res = opa - opb;
      FN_AND:  res = opa & opb;
      FN_OR:   res = opa | opb;
      default: res = opa + opb;
    endcase
  end

  assign zero = (res == '0);

endmodule

// File: rtl/sc_rv_core.sv
module sc_rv_core
  import core_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_wen,
  output logic            dmem_ren,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int IDX_W      = $clog2(NREG);
  localparam int SYNC_DEPTH = 2;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  // Reset release synchroniser
  logic [SYNC_DEPTH-1:0] sync_q;
  logic [SYNC_DEPTH-1:0] sync_d;
  logic                  core_run;

  assign sync_d = {sync_q[SYNC_DEPTH-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign core_run = sync_q[SYNC_DEPTH-1];

  // Program counter
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_d;
  logic [XLEN-1:0] pc_seq;
  logic [XLEN-1:0] pc_tgt;
  logic            take_br;

  // Decode
  ctrl_t     ctrl;
  alu_fn_e   alu_fn;
  imm_kind_e imm_kind;

  core_decode u_decode (
    .clk       (clk),
    .rst_n     (core_run),
    .opcode    (imem_rdata[6:0]),
    .funct3    (imem_rdata[14:12]),
    .funct7_b5 (imem_rdata[30]),
    .ctrl      (ctrl),
    .alu_fn    (alu_fn),
    .imm_kind  (imm_kind)
  );

  logic [XLEN-1:0] imm;

  core_immgen #(.XLEN(XLEN)) u_immgen (
    .instr_hi (imem_rdata[31:7]),
    .kind     (imm_kind),
    .imm      (imm)
  );

  // Register file
  logic [XLEN-1:0] rs1_val;
  logic [XLEN-1:0] rs2_val;
  logic [XLEN-1:0] wb_val;
  logic            rf_we;
  logic [XLEN-1:0] alu_res;
  logic            alu_zero;
  logic [XLEN-1:0] alu_opb;

  assign rf_we  = ctrl.reg_we && core_run;
  assign wb_val = ctrl.wb_from_mem ? dmem_rdata : alu_res;

  core_regfile #(.XLEN(XLEN), .NREG(NREG)) u_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (rf_we),
    .wr_idx    (imem_rdata[7+IDX_W-1:7]),
    .wr_data   (wb_val),
    .rd_idx_a  (imem_rdata[15+IDX_W-1:15]),
    .rd_idx_b  (imem_rdata[20+IDX_W-1:20]),
    .rd_data_a (rs1_val),
    .rd_data_b (rs2_val)
  );

  assign alu_opb = ctrl.opb_imm ? imm : rs2_val;

  core_alu #(.XLEN(XLEN)) u_alu (
    .opa  (rs1_val),
    .opb  (alu_opb),
    .fn   (alu_fn),
    .res  (alu_res),
    .zero (alu_zero)
  );

  // Next PC
  always_comb begin
    pc_seq  = pc_q + STEP;
    pc_tgt  = pc_q + {imm[XLEN-2:0], 1'b0};
    take_br = ctrl.is_branch && alu_zero;
    pc_d    = take_br ? pc_tgt : pc_seq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= '0;
    else if (core_run) pc_q <= pc_d;
  end

  // Memory ports
  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_res;
  assign dmem_wdata = rs2_val;
  assign dmem_wen   = ctrl.mem_we && core_run;
  assign dmem_ren   = ctrl.mem_re && core_run;

  AST_IDLE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !core_run |-> (!dmem_wen && !dmem_ren && (imem_addr == '0))); // R1
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!core_run)
    !take_br |=> (pc_q == $past(pc_q) + STEP)); // R7
  AST_PC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[1:0] == 2'b00); // R7
  AST_BR_TARGET: assert property (@(posedge clk) disable iff (!core_run)
    take_br |=> (pc_q == $past(pc_q) + {$past(imm[XLEN-2:0]), 1'b0})); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_wen && dmem_ren)); // R10

endmodule

// File: tb/tb_sc_rv_core.sv
module tb_sc_rv_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] imem_addr;
  logic [31:0] imem_rdata;
  logic [63:0] dmem_addr;
  logic [63:0] dmem_wdata;
  logic        dmem_wen;
  logic        dmem_ren;
  logic [63:0] dmem_rdata;

  always #5 clk = ~clk;

  logic [31:0] imem    [64];
  logic [63:0] dmem    [32];
  logic [63:0] ref_mem [32];
  logic [63:0] init_mem[32];
  logic [63:0] mreg    [32];
  logic [63:0] mpc;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  sc_rv_core dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_wen   (dmem_wen),
    .dmem_ren   (dmem_ren),
    .dmem_rdata (dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:3]];

  always @(posedge clk) if (dmem_wen) dmem[dmem_addr[7:3]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input int rs2, input int rs1,
                                        input logic [2:0] f3, input int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
  endfunction

  function automatic logic [31:0] enc_ld(input int rd, input int rs1, input int off);
    logic [11:0] o = 12'(off);
    return {o, 5'(rs1), 3'b011, 5'(rd), 7'b0000011};
  endfunction

  function automatic logic [31:0] enc_sd(input int rs2, input int rs1, input int off);
    logic [11:0] o = 12'(off);
    return {o[11:5], 5'(rs2), 5'(rs1), 3'b011, o[4:0], 7'b0100011};
  endfunction

  function automatic logic [31:0] enc_beq(input int rs1, input int rs2, input int off);
    logic [12:0] o = 13'(off);
    return {o[12], o[10:5], 5'(rs2), 5'(rs1), 3'b000, o[4:1], o[11], 7'b1100011};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural reference: checks the ports for the current instruction, then retires it
  task automatic model_cycle(inout string pc_tag);
    logic [31:0] ins;
    logic [63:0] a, b, ea, res, nxt;
    int          rd;
    longint      off;
    bit          is_ld, is_sd;
    ins = imem[mpc[7:2]];
    chk(pc_tag, imem_addr, mpc);
    a   = mreg[ins[19:15]];
    b   = mreg[ins[24:20]];
    rd  = int'(ins[11:7]);
    nxt = mpc + 64'd4;
    is_ld = (ins[6:0] == 7'h03);
    is_sd = (ins[6:0] == 7'h23);
    chk("R10 strobes", {63'd0, dmem_wen & dmem_ren}, 64'd0);
    chk(is_sd ? "R5 wen" : "R9 wen idle", {63'd0, dmem_wen}, {63'd0, is_sd});
    chk(is_ld ? "R4 ren" : "R2 ren idle", {63'd0, dmem_ren}, {63'd0, is_ld});
    pc_tag = "R7 pc";
    if (ins[6:0] == 7'h33) begin
      case ({ins[30], ins[14:12]})
        4'b0000: res = a + b;
        4'b1000: res = a - b;
        4'b0111, 4'b1111: res = a & b;
        4'b0110, 4'b1110: res = a | b;
        default: res = a + b;
      endcase
      if (rd != 0) mreg[rd] = res;
    end else if (is_ld) begin
      off = longint'($signed(ins[31:20]));
      ea  = a + 64'(off);
      chk("R4 load addr", dmem_addr, ea);
      if (rd != 0) mreg[rd] = ref_mem[ea[7:3]];
    end else if (is_sd) begin
      off = longint'($signed({ins[31:25], ins[11:7]}));
      ea  = a + 64'(off);
      chk("R5 store addr", dmem_addr, ea);
      chk("R5 store data", dmem_wdata, b);
      ref_mem[ea[7:3]] = b;
    end else if (ins[6:0] == 7'h63) begin
      off = longint'($signed({ins[31], ins[7], ins[30:25], ins[11:8], 1'b0}));
      pc_tag = "R6 pc";
      if (a == b) nxt = mpc + 64'(off);
    end else begin
      pc_tag = "R9 pc";
    end
    mpc = nxt;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string tag;
    for (int i = 0; i < 64; i++) imem[i] = 32'h0;
    for (int i = 0; i < 32; i++) init_mem[i] = 64'hA5A5_0000_0000_0000 + 64'(i);
    init_mem[0]  = 64'h1234_5678_9ABC_DEF0;
    init_mem[1]  = 64'h0F0F_0F0F_F0F0_F0F0;
    init_mem[2]  = 64'hFFFF_FFFF_FFFF_FFFB;
    init_mem[3]  = 64'd136;
    init_mem[16] = 64'hCAFE_0000_BEEF_5555;
    for (int i = 0; i < 32; i++) begin
      dmem[i]    = init_mem[i];
      ref_mem[i] = init_mem[i];
      mreg[i]    = 64'd0;
    end

    imem[0]  = enc_ld(1, 0, 0);
    imem[1]  = enc_ld(2, 0, 8);
    imem[2]  = enc_ld(3, 0, 16);
    imem[3]  = enc_r(7'h00, 2, 1, 3'b000, 4);
    imem[4]  = enc_r(7'h20, 2, 1, 3'b000, 5);
    imem[5]  = enc_r(7'h00, 2, 1, 3'b111, 6);
    imem[6]  = enc_r(7'h00, 3, 1, 3'b110, 7);
    imem[7]  = enc_sd(4, 0, 64);
    imem[8]  = enc_sd(5, 0, 72);
    imem[9]  = enc_sd(6, 0, 80);
    imem[10] = enc_sd(7, 0, 88);
    imem[11] = enc_r(7'h00, 2, 1, 3'b000, 0);
    imem[12] = enc_sd(0, 0, 96);
    imem[13] = enc_beq(1, 2, 8);
    imem[14] = enc_beq(1, 1, 12);
    imem[15] = enc_sd(1, 0, 104);
    imem[16] = enc_sd(1, 0, 112);
    imem[17] = 32'h1234_50B7;          // opcode 0110111, outside the subset
    imem[18] = enc_sd(1, 0, 152);
    imem[19] = enc_ld(9, 0, 24);
    imem[20] = enc_sd(2, 9, -16);
    imem[21] = enc_ld(11, 9, -8);
    imem[22] = enc_sd(11, 9, 8);
    imem[23] = enc_r(7'h00, 9, 10, 3'b000, 10);
    imem[24] = enc_beq(0, 0, -4);

    mpc   = 64'd0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", imem_addr, 64'd0);
    chk("R1 reset wen", {63'd0, dmem_wen}, 64'd0);
    chk("R1 reset ren", {63'd0, dmem_ren}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sync pc", imem_addr, 64'd0);
    chk("R1 sync wen", {63'd0, dmem_wen}, 64'd0);
    chk("R1 sync ren", {63'd0, dmem_ren}, 64'd0);
    @(negedge clk);

    tag = "R1 first pc";
    for (int c = 0; c < 44; c++) begin
      model_cycle(tag);
      @(negedge clk);
    end

    chk("R2 R3 add", dmem[8], init_mem[0] + init_mem[1]);
    chk("R3 sub", dmem[9], init_mem[0] - init_mem[1]);
    chk("R3 and", dmem[10], init_mem[0] & init_mem[1]);
    chk("R3 or", dmem[11], init_mem[0] | init_mem[2]);
    chk("R8 x0", dmem[12], 64'd0);
    chk("R6 skipped store a", dmem[13], init_mem[13]);
    chk("R6 skipped store b", dmem[14], init_mem[14]);
    chk("R9 x1 kept", dmem[19], init_mem[0]);
    chk("R5 negative offset", dmem[15], init_mem[1]);
    chk("R4 negative offset", dmem[18], init_mem[16]);
    for (int i = 0; i < 32; i++) chk("R2 memory image", dmem[i], ref_mem[i]);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule